// File: doc/BRIEF.md
# Fixed-Priority Masked Interrupt Controller

This block gathers 21 level-sensitive request lines from peripherals and turns them into two request outputs toward a processor core: a normal interrupt (irq) and a fast interrupt (fiq). Software programs it through a small word-addressed register bus. Each source has a disable bit: a set bit blocks the source and a clear bit lets it through. Each source also has a route bit that sends it to the fast output instead of the normal one.

Among the sources that are requesting, enabled and routed to the normal output, a fixed-priority arbiter picks the one with the highest number. Source 20 beats every other source and source 0 loses to all of them. The winner's index appears on dedicated output pins and also in a read-only register. An interrupt handler reads that register to learn which source to service. Requests are not latched, so a source stops counting as pending as soon as its line drops.

Top module: `intc_top`

## Requirements
- R1: After reset the disable register reads 0x001FFFFF (all sources blocked), the route register reads 0, and irq, fiq and irqIdxValid are 0.
- R2: The disable register is at word address 0. A 1 in bit n blocks source n and a 0 lets it through. A write takes effect from the clock edge that accepts it.
- R3: The route register is at word address 1. A 1 in bit n sends source n to fiq and a 0 sends it to irq.
- R4: Bits 31:21 of a write to the disable or route register are discarded, and those bits always read back as 0.
- R5: A read at word address 2 returns the raw request lines in bits 20:0, whatever the disable and route settings, with bits 31:21 at 0.
- R6: irq is 1 exactly when some source is requesting, not blocked and routed to irq.
- R7: fiq is 1 exactly when some source is requesting, not blocked and routed to fiq.
- R8: irqIdx gives the highest-numbered source that is requesting, not blocked and routed to irq. irqIdxValid is 1 exactly when such a source exists. Sources routed to fiq never take part.
- R9: A read at word address 3 returns the winning index in bits 4:0 and a valid flag in bit 8. When no source qualifies, the whole word reads 0.
- R10: Sources are level-sensitive. Dropping a request line removes that source from irq, fiq, the winner and the pending read in the same cycle, with no clear operation.
- R11: Writes to word addresses 2 and 3 change no state. The busRdata bus reads 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWordAddr | input | 2 | Word address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle |
| srcReq | input | 21 | Level-sensitive request lines |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |
| irqIdx | output | 5 | Index of the winning normal-route source |
| irqIdxValid | output | 1 | irqIdx is meaningful |

## Verification
The bench applies dense random request words, which mostly test that the highest set bit wins. It also applies sparse single- and two-bit patterns, which separate off-by-one errors in the index and reversed priority order. Random disable and route values isolate the inverted gate polarity and the split between fiq and irq. Directed cases cover the extreme levels 0 and 20, a fast-routed level 20 sitting above a normal level 19, and stray upper write bits. They also cover writes to the read-only addresses and a request dropping with no clear.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Word-address decode of the register bus
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_MODE = 2'd1,
    SEL_PEND = 2'd2,
    SEL_WIN  = 2'd3
  } regSel_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic    wrMask;
    logic    wrMode;
    logic    rdEn;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [1:0]  busWordAddr,
  output ctrlStrobe_t strb
);

  regSel_e sel;

  always_comb begin
    sel = regSel_e'(busWordAddr);
    strb.rdSel  = sel;
    strb.rdEn   = busSel && !busWrite;
    // only the two writable registers accept writes; others drop them
    strb.wrMask = busSel && busWrite && (sel == SEL_MASK);
    strb.wrMode = busSel && busWrite && (sel == SEL_MODE);
  end

endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int NUM_SRC = 21,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req,
  output logic [IDX_W-1:0]   idx,
  output logic               valid
);

  // later (higher) indices overwrite earlier ones: highest number wins
  always_comb begin
    idx   = '0;
    valid = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i]) begin
        idx   = IDX_W'(i);
        valid = 1'b1;
      end
    end
  end

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC   = 21,
  parameter int DATA_W    = 32,
  parameter int VALID_BIT = 8,
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] srcReq,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq,
  output logic               fiq,
  output logic [IDX_W-1:0]   irqIdx,
  output logic               irqIdxValid
);

  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] modeQ;
  logic [NUM_SRC-1:0] liveReq;
  logic [NUM_SRC-1:0] irqReq;
  logic [NUM_SRC-1:0] fiqReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
      modeQ <= '0;
    end else begin
      if (strb.wrMask) maskQ <= wrData;
      if (strb.wrMode) modeQ <= wrData;
    end
  end

  // inverted-polarity gate: cleared mask bit lets the source through
  assign liveReq = srcReq & ~maskQ;
  assign irqReq  = liveReq & ~modeQ;
  assign fiqReq  = liveReq & modeQ;
  assign irq     = |irqReq;
  assign fiq     = |fiqReq;

  intc_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
    .req   (irqReq),
    .idx   (irqIdx),
    .valid (irqIdxValid)
  );

  always_comb begin
    rdData = '0;
    if (strb.rdEn) begin
      unique case (strb.rdSel)
        SEL_MASK: rdData = DATA_W'(maskQ);
        SEL_MODE: rdData = DATA_W'(modeQ);
        SEL_PEND: rdData = DATA_W'(srcReq);
        SEL_WIN: begin
          if (irqIdxValid) begin
            rdData[IDX_W-1:0] = irqIdx;
            rdData[VALID_BIT] = 1'b1;
          end
        end
        default: rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/intc_top.sv
module intc_top #(
  parameter int NUM_SRC = 21,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [1:0]         busWordAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcReq,
  output logic               irq,
  output logic               fiq,
  output logic [IDX_W-1:0]   irqIdx,
  output logic               irqIdxValid
);

  intc_pkg::ctrlStrobe_t strb;
  logic unusedWdataHi;

  assign unusedWdataHi = ^busWdata[DATA_W-1:NUM_SRC];

  intc_ctrl u_ctrl (
    .busSel      (busSel),
    .busWrite    (busWrite),
    .busWordAddr (busWordAddr),
    .strb        (strb)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (busWdata[NUM_SRC-1:0]),
    .srcReq      (srcReq),
    .rdData      (busRdata),
    .irq         (irq),
    .fiq         (fiq),
    .irqIdx      (irqIdx),
    .irqIdxValid (irqIdxValid)
  );

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int NUM_SRC = 21,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWrite,
  input logic [1:0]         busWordAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic [NUM_SRC-1:0] srcReq,
  input logic               irq,
  input logic               fiq,
  input logic [IDX_W-1:0]   irqIdx,
  input logic               irqIdxValid
);

  // R1: the cycle after a reset edge, nothing is requested
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    !rstN |=> (!irq && !fiq && !irqIdxValid));

  // R2: blocking every source silences both outputs next cycle
  assert_full_mask_silences_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busWordAddr == 2'd0 && (&busWdata[NUM_SRC-1:0]))
    |=> (!irq && !fiq));

  // R4: upper bits of the writable registers read as zero
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && !busWordAddr[1]) |-> (busRdata[DATA_W-1:NUM_SRC] == '0));

  // R5: pending read mirrors the request lines
  assert_pending_raw_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && busWordAddr == 2'd2) |-> (busRdata == DATA_W'(srcReq)));

  // R6/R8: a normal request exists exactly when the winner is valid
  assert_irq_matches_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq == irqIdxValid);

  // R8: the winner is an active request line
  assert_winner_requesting_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqIdxValid |-> (irqIdx <= IDX_W'(NUM_SRC - 1)) && srcReq[irqIdx]);

  // R10: with no request at all, both outputs are low
  assert_no_req_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq == '0) |-> (!irq && !fiq));

  // R11: no read in progress means a zero read bus
  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWrite) |-> (busRdata == '0));

endmodule

bind intc_top intc_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) chk (.*);

// File: tb/intc_top_test.sv
module intc_top_test;

  localparam int NS = 21;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busWordAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NS-1:0] srcReq = '0;
  logic        irq, fiq, irqIdxValid;
  logic [4:0]  irqIdx;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;
  logic [NS-1:0] mMask, mMode;

  always #5 clk = ~clk;

  intc_top uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busWordAddr(busWordAddr), .busWdata(busWdata), .busRdata(busRdata),
    .srcReq(srcReq), .irq(irq), .fiq(fiq), .irqIdx(irqIdx),
    .irqIdxValid(irqIdxValid)
  );

  function automatic logic [NS-1:0] elig(input logic fast);
    return srcReq & ~mMask & (fast ? mMode : ~mMode);
  endfunction

  function automatic logic [31:0] expWin();
    logic [NS-1:0] e = elig(1'b0);
    logic [31:0] w = '0;
    for (int i = 0; i < NS; i++) if (e[i]) w = 32'h100 | i;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busWordAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWrite = 0; busWdata = '0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busWordAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic setMask(input logic [31:0] d);
    busWr(2'd0, d); mMask = d[NS-1:0];
  endtask

  task automatic setMode(input logic [31:0] d);
    busWr(2'd1, d); mMode = d[NS-1:0];
  endtask

  // full comparison of outputs and read-only registers
  task automatic checkAll(input string tag);
    logic [31:0] r;
    @(negedge clk); #2;
    check({tag, " R6 irq"}, {31'b0, irq}, {31'b0, |elig(1'b0)});
    check({tag, " R7 fiq"}, {31'b0, fiq}, {31'b0, |elig(1'b1)});
    check({tag, " R8 idx"}, {23'b0, irqIdxValid, 3'b0, irqIdx}, expWin());
    busRd(2'd3, r); check({tag, " R9 winner reg"}, r, expWin());
    busRd(2'd2, r); check({tag, " R5 pending"}, r, {11'b0, srcReq});
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h1234_5678));
    mMask = '1; mMode = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    busRd(2'd0, r); check("R1 mask reset", r, 32'h001F_FFFF);
    busRd(2'd1, r); check("R1 mode reset", r, 32'h0);
    srcReq = '1;
    #1 check("R1 outputs quiet", {29'b0, irq, fiq, irqIdxValid}, 32'h0);
    check("R11 idle rdata", busRdata, 32'h0);

    // R2 enable all, priority to 20
    setMask(32'h0);
    checkAll("R2 all enabled");
    check("R8 top level wins", {27'b0, irqIdx}, 32'd20);

    // R4 upper bits discarded
    setMask(32'hFFE0_0000);
    busRd(2'd0, r); check("R4 mask upper", r, 32'h0);
    setMode(32'hFFFF_FFFF);
    busRd(2'd1, r); check("R4 mode upper", r, 32'h001F_FFFF);
    setMode(32'h0);

    // R8 lowest level alone
    srcReq = 21'h1;
    checkAll("R8 level0");
    // R3/R8 fast-routed 20 above normal 19
    setMode(32'h0010_0000);
    srcReq = 21'h18_0000;
    checkAll("R3 fiq20 irq19");
    check("R8 idx19", {27'b0, irqIdx}, 32'd19);

    // R11 writes to read-only addresses change nothing
    busWr(2'd2, 32'h0);
    busWr(2'd3, 32'hFFFF_FFFF);
    busRd(2'd0, r); check("R11 mask kept", r, 32'h0);
    busRd(2'd1, r); check("R11 mode kept", r, 32'h0010_0000);

    // R10 drop line, no clear needed
    srcReq = 21'h10_0000;
    checkAll("R10 drop 19");
    srcReq = '0;
    checkAll("R10 all dropped");

    // R2 blocked source ignored at outputs
    setMode(32'h0);
    setMask(32'h0000_0004);
    srcReq = 21'h4;
    checkAll("R2 blocked");

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op = $urandom_range(0, 3);
      if (op == 0) setMask($urandom);
      else if (op == 1) setMode($urandom);
      else if ($urandom_range(0, 1) == 1) srcReq = NS'($urandom);
      else srcReq = (NS'(1) << $urandom_range(0, NS - 1)) | (NS'(1) << $urandom_range(0, NS - 1));
      checkAll("rand");
    end
    finishRun();
  end

endmodule